// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes frames that an upstream filter has already accepted and lays them into a circular receive area inside a local byte-wide packet memory. The area is organised in 256-byte pages and bounded by a programmable first page and a programmable end page (the first page past the area). Each stored frame starts on a page boundary with a four-byte descriptor: a status byte, the page where the following frame will begin, and the stored length in two bytes. The frame bytes follow the descriptor and fold back to the first page when they reach the end page.

Four page registers are held here: ring first page, ring end page, the host's read boundary page and the current write page. Before it commits to a frame the block checks whether the ring can take a maximum-size frame. When it cannot, or when reception is halted or the frame is not accepted, the frame is consumed and discarded. Short frames are filled with zero bytes to a minimum length. When a frame has been fully stored, the current page moves to the page computed for the next frame and a one-cycle completion pulse is raised.

The block writes one byte per clock through a plain memory write port. A source presents one byte per cycle with start and end markers, and the frame length and accept flag come with the start marker. While `busy` is high the source holds back its next byte.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the four page registers read 0, and `busy`, `mem_we` and `rx_done` are low.
- R2: A configuration write selects a register with `cfg_sel` (0 first page, 1 end page, 2 boundary, 3 current page). A first-page or end-page value is taken only if it is at most `PG_END` (128). A boundary or current-page value is taken only if it is below `PG_END`. A rejected write leaves the register unchanged.
- R3: A frame is discarded when `halt` is high at its start byte, when `in_accept` is low, when the end page is not above the first page, or when free space is under 1518 bytes. Free space is boundary*256 - current*256 if current < boundary, and otherwise (end - first)*256 - (current - boundary)*256. A discarded frame makes no memory write, no `rx_done` pulse and no change to the current page.
- R4: The descriptor is written at current*256. Its bytes are: status (0x01, plus 0x20 when bit 0 of the frame's first byte is 1), next page, total length low byte, and total length high byte.
- R5: A frame shorter than 60 bytes is stored as 60 bytes, with zero bytes after its last real byte. The total length is the stored length plus 4. Exactly 4 + stored-length writes are made.
- R6: Frame bytes are written in order starting at current*256 + 4. An address that reaches end*256 continues at first*256, and every write lands inside the ring.
- R7: The next page is (current*256 + ((total + 4 + 255) rounded down to a multiple of 256)) / 256, reduced by (end - first) when the sum reaches end*256. In the cycle `rx_done` pulses for exactly one cycle, the current page register shows this value. The current page changes only then or after a configuration write.
- R8: After an accepted start byte, `busy` is high for exactly 5 cycles, covering the four descriptor writes and the first frame byte. It is also high while zero padding is written. A discarded frame never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Reception halted; sampled with the start byte |
| cfg_we | input | 1 | Page register write strobe |
| cfg_sel | input | 2 | Page register select |
| cfg_wdata | input | 8 | Page value to write |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| in_len | input | 16 | Frame length in bytes, valid with the start byte |
| in_accept | input | 1 | Frame passed filtering, valid with the start byte |
| busy | output | 1 | Source must hold its next byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rx_done | output | 1 | One-cycle pulse when a frame is stored |
| start_pg | output | 8 | Ring first page |
| stop_pg | output | 8 | Ring end page |
| bnd_pg | output | 8 | Boundary page |
| cur_pg | output | 8 | Current write page |

## Verification
Frame lengths are swept across the padding edge (1, 2, 59, 60, 61) and across the page-count edges of the next-page formula (247, 248, 249), and up to the 1514-byte maximum. This separates an off-by-one in padding from one in page rounding. Separate frames are placed so that their data folds past the end page, and so that only their next-page value wraps to the first page. This tells a data-address wrap fault apart from a pointer wrap fault. The free-space check is tried on both sides of the 1518-byte limit, with the boundary above and below the current page. Halt, a refused accept flag and a collapsed ring each show that a discarded frame leaves memory, the pulse and the current page untouched.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int PG_W   = 8;
    localparam int ADDR_W = PG_W + 8;
    localparam int LEN_W  = 16;

    typedef enum logic [1:0] {
        SEL_FIRST = 2'd0,
        SEL_END   = 2'd1,
        SEL_BND   = 2'd2,
        SEL_CUR   = 2'd3
    } rxr_sel_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HDR   = 3'd1,
        S_FIRST = 3'd2,
        S_DATA  = 3'd3,
        S_PAD   = 3'd4,
        S_SKIP  = 3'd5
    } rxr_state_e;

    typedef struct packed {
        logic [PG_W-1:0] first;
        logic [PG_W-1:0] last;
        logic [PG_W-1:0] bnd;
        logic [PG_W-1:0] cur;
    } rxr_pages_t;
endpackage

// File: rtl/rxr_page_regs.sv
module rxr_page_regs
    import rxr_pkg::*;
#(
    parameter int PG_END = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [7:0]      cfg_wdata,
    input  logic            cur_load,
    input  logic [PG_W-1:0] cur_next,
    output rxr_pages_t      pages
);
    localparam logic [PG_W:0] END_LIM = (PG_W+1)'(PG_END);

    rxr_pages_t pg_d, pg_q;
    logic [PG_W:0] wval;

    always_comb begin
        pg_d = pg_q;
        wval = {1'b0, PG_W'(cfg_wdata)};
        if (cfg_we) begin
            case (rxr_sel_e'(cfg_sel))
                SEL_FIRST: if (wval <= END_LIM) pg_d.first = PG_W'(cfg_wdata);
                SEL_END:   if (wval <= END_LIM) pg_d.last  = PG_W'(cfg_wdata);
                SEL_BND:   if (wval <  END_LIM) pg_d.bnd   = PG_W'(cfg_wdata);
                default:   if (wval <  END_LIM) pg_d.cur   = PG_W'(cfg_wdata);
            endcase
        end
        if (cur_load) pg_d.cur = cur_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign pages = pg_q;
endmodule

// File: rtl/rxr_ring_calc.sv
module rxr_ring_calc
    import rxr_pkg::*;
#(
    parameter int MIN_LEN = 60,
    parameter int ROOM    = 1518
) (
    input  rxr_pages_t        pages,
    input  logic [LEN_W-1:0]  len,
    output logic              full,
    output logic [LEN_W-1:0]  pad_len,
    output logic [LEN_W-1:0]  tot_len,
    output logic [PG_W-1:0]   next_pg,
    output logic [ADDR_W-1:0] base
);
    localparam int CW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

    logic [CW-1:0] first_a, end_a, bnd_a, cur_a, ring, avail, span, nxt_a;

    always_comb begin
        first_a = CW'({pages.first, 8'h00});
        end_a   = CW'({pages.last,  8'h00});
        bnd_a   = CW'({pages.bnd,   8'h00});
        cur_a   = CW'({pages.cur,   8'h00});
        ring    = end_a - first_a;

        if (cur_a < bnd_a) avail = bnd_a - cur_a;
        else               avail = ring - (cur_a - bnd_a);
        full = (end_a <= first_a) || (avail < CW'(ROOM));

        pad_len = (len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len;
        tot_len = pad_len + LEN_W'(4);
        span    = (CW'(tot_len) + CW'(4 + 255)) & ~CW'(255);
        nxt_a   = cur_a + span;
        if (nxt_a >= end_a) nxt_a = nxt_a - ring;
        next_pg = PG_W'(nxt_a >> 8);
        base    = ADDR_W'(cur_a);
    end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int PG_END  = 128,
    parameter int MIN_LEN = 60,
    parameter int ROOM    = 1518
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        halt,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [7:0]  in_data,
    input  logic [15:0] in_len,
    input  logic        in_accept,
    output logic        busy,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        rx_done,
    output logic [7:0]  start_pg,
    output logic [7:0]  stop_pg,
    output logic [7:0]  bnd_pg,
    output logic [7:0]  cur_pg
);
    typedef struct packed {
        rxr_state_e        st;
        logic [1:0]        hcnt;
        logic [ADDR_W-1:0] wa;
        logic [LEN_W-1:0]  pos;
        logic [LEN_W-1:0]  plen;
        logic [LEN_W-1:0]  tot;
        logic [PG_W-1:0]   nxt;
        logic [7:0]        stat;
        logic [7:0]        first;
        logic              eop_seen;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } wr_state_t;

    wr_state_t d, q;

    rxr_pages_t        pages;
    logic              full;
    logic [LEN_W-1:0]  pad_len, tot_len, pos_n;
    logic [PG_W-1:0]   next_pg;
    logic [ADDR_W-1:0] base;
    logic              finish;
    logic [7:0]        hdr_byte;

    rxr_page_regs #(.PG_END(PG_END)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .cur_load (finish),
        .cur_next (q.nxt),
        .pages    (pages)
    );

    rxr_ring_calc #(.MIN_LEN(MIN_LEN), .ROOM(ROOM)) u_calc (
        .pages  (pages),
        .len    (in_len),
        .full   (full),
        .pad_len(pad_len),
        .tot_len(tot_len),
        .next_pg(next_pg),
        .base   (base)
    );

    // Advance a write address by one, folding the end page back to the first page.
    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                                input rxr_pages_t p);
        logic [ADDR_W-1:0] n;
        n = a + ADDR_W'(1);
        if (n == {p.last, 8'h00}) n = {p.first, 8'h00};
        return n;
    endfunction

    always_comb begin
        case (q.hcnt)
            2'd0:    hdr_byte = q.stat;
            2'd1:    hdr_byte = 8'(q.nxt);
            2'd2:    hdr_byte = q.tot[7:0];
            default: hdr_byte = q.tot[15:8];
        endcase
    end

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.done  = 1'b0;
        finish  = 1'b0;
        pos_n   = q.pos + LEN_W'(1);
        case (q.st)
            S_IDLE: begin
                if (in_valid && in_sop) begin
                    if (in_accept && !halt && !full) begin
                        d.st       = S_HDR;
                        d.hcnt     = 2'd0;
                        d.wa       = base;
                        d.pos      = '0;
                        d.plen     = pad_len;
                        d.tot      = tot_len;
                        d.nxt      = next_pg;
                        d.stat     = in_data[0] ? 8'h21 : 8'h01;
                        d.first    = in_data;
                        d.eop_seen = in_eop;
                    end else if (!in_eop) begin
                        d.st = S_SKIP;
                    end
                end
            end
            S_HDR: begin
                d.we    = 1'b1;
                d.addr  = q.wa;
                d.wdata = hdr_byte;
                d.wa    = step(q.wa, pages);
                d.hcnt  = q.hcnt + 2'd1;
                if (q.hcnt == 2'd3) d.st = S_FIRST;
            end
            S_FIRST: begin
                d.we    = 1'b1;
                d.addr  = q.wa;
                d.wdata = q.first;
                d.wa    = step(q.wa, pages);
                d.pos   = pos_n;
                if (!q.eop_seen)        d.st = S_DATA;
                else if (pos_n < q.plen) d.st = S_PAD;
                else                     finish = 1'b1;
            end
            S_DATA: begin
                if (in_valid) begin
                    if (q.pos < q.plen) begin
                        d.we    = 1'b1;
                        d.addr  = q.wa;
                        d.wdata = in_data;
                        d.wa    = step(q.wa, pages);
                    end
                    d.pos = pos_n;
                    if (in_eop) begin
                        if (pos_n < q.plen) d.st = S_PAD;
                        else                finish = 1'b1;
                    end
                end
            end
            S_PAD: begin
                d.we    = 1'b1;
                d.addr  = q.wa;
                d.wdata = 8'h00;
                d.wa    = step(q.wa, pages);
                d.pos   = pos_n;
                if (pos_n >= q.plen) finish = 1'b1;
            end
            S_SKIP: begin
                if (in_valid && in_eop) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
        if (finish) begin
            d.st   = S_IDLE;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st == S_HDR) || (q.st == S_FIRST) || (q.st == S_PAD);
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign rx_done   = q.done;
    assign start_pg  = pages.first;
    assign stop_pg   = pages.last;
    assign bnd_pg    = pages.bnd;
    assign cur_pg    = pages.cur;
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
    parameter int PG_END = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        halt,
    input logic        in_valid,
    input logic        in_sop,
    input logic        in_accept,
    input logic        cfg_we,
    input logic        busy,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        rx_done,
    input logic [7:0]  start_pg,
    input logic [7:0]  stop_pg,
    input logic [7:0]  bnd_pg,
    input logic [7:0]  cur_pg
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    pg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, start_pg} <= 9'(PG_END)) && ({1'b0, stop_pg} <= 9'(PG_END))
        && ({1'b0, bnd_pg} < 9'(PG_END)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R7
    cur_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (cur_pg != $past(cur_pg))) |-> (rx_done || $past(cfg_we)));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(busy) && !mem_we)
            |-> $past(in_valid && in_sop && in_accept && !halt));

    // R6
    ring_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr >= {start_pg, 8'h00}) && (mem_addr < {stop_pg, 8'h00})));
endmodule

bind rxr_ring_writer rxr_ring_chk #(.PG_END(PG_END)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_accept(in_accept),
    .cfg_we   (cfg_we),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rx_done  (rx_done),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .bnd_pg   (bnd_pg),
    .cur_pg   (cur_pg)
);

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic [15:0] in_len = '0;
    logic        in_accept = 1'b0;
    logic        busy, mem_we, rx_done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, start_pg, stop_pg, bnd_pg, cur_pg;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [7:0] mem [int];

    rxr_ring_writer u0 (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (rx_done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] fbyte(input int i, input int seed, input bit odd);
        if (i == 0) return 8'((seed & 8'hFE) | int'(odd));
        return 8'((i * 7 + seed) & 8'hFF);
    endfunction

    task automatic send_frame(input int len, input bit odd, input int seed,
                              input bit acc, input bit store, input string req);
        int w0, d0, c0, bc, plen, tot, base, span, nxt, a, first_a, end_a, wt;
        logic [7:0] expb;
        bit okd;
        mem.delete();
        w0 = wr_cnt; d0 = done_cnt; c0 = int'(cur_pg);
        first_a = int'(start_pg) * 256; end_a = int'(stop_pg) * 256;
        plen = (len < 60) ? 60 : len;
        tot  = plen + 4;
        base = c0 * 256;
        span = ((tot + 4 + 255) / 256) * 256;
        nxt  = base + span;
        if (nxt >= end_a) nxt = nxt - (end_a - first_a);
        @(negedge clk);
        in_valid = 1'b1; in_sop = 1'b1; in_eop = (len == 1);
        in_data = fbyte(0, seed, odd); in_len = 16'(len); in_accept = acc;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        bc = 0;
        while (busy && bc < 200) begin bc++; @(negedge clk); end
        if (len > 1) chk(bc == (store ? 5 : 0), "R8 busy after start", bc, store ? 5 : 0);
        for (int i = 1; i < len; i++) begin
            while (busy) @(negedge clk);
            in_valid = 1'b1; in_data = fbyte(i, seed, odd); in_eop = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_eop = 1'b0;
        if (store) begin
            wt = 0;
            while (done_cnt == d0 && wt < 3000) begin wt++; @(negedge clk); end
            chk(done_cnt == d0 + 1, {req, " R7 done pulse"}, done_cnt - d0, 1);
            chk(int'(cur_pg) == nxt / 256, {req, " R7 next page"}, cur_pg, nxt / 256);
            @(negedge clk);
            chk(wr_cnt - w0 == 4 + plen, {req, " R5 write count"}, wr_cnt - w0, 4 + plen);
            chk(mem[base] == (odd ? 8'h21 : 8'h01), {req, " R4 status"}, mem[base], odd ? 8'h21 : 8'h01);
            chk(mem[base+1] == 8'(nxt / 256), {req, " R4 next byte"}, mem[base+1], nxt / 256);
            chk({mem[base+3], mem[base+2]} == 16'(tot), {req, " R4 length"},
                {mem[base+3], mem[base+2]}, tot);
            okd = 1'b1;
            a = base + 4;
            for (int i = 0; i < plen; i++) begin
                expb = (i < len) ? fbyte(i, seed, odd) : 8'h00;
                if (!mem.exists(a) || mem[a] !== expb) okd = 1'b0;
                a++;
                if (a == end_a) a = first_a;
            end
            chk(okd, {req, " R6 R5 data and padding"}, okd, 1);
        end else begin
            repeat (20) @(negedge clk);
            chk(wr_cnt == w0, {req, " R3 no writes"}, wr_cnt - w0, 0);
            chk(done_cnt == d0, {req, " R3 no done"}, done_cnt - d0, 0);
            chk(int'(cur_pg) == c0, {req, " R3 current kept"}, cur_pg, c0);
        end
    endtask

    initial begin
        int lens [12] = '{1, 2, 59, 60, 61, 100, 247, 248, 249, 500, 1000, 1514};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(start_pg == 0 && stop_pg == 0, "R1 first/end pages", {start_pg, stop_pg}, 0);
        chk(bnd_pg == 0 && cur_pg == 0, "R1 boundary/current", {bnd_pg, cur_pg}, 0);
        chk(!busy && !mem_we && !rx_done, "R1 outputs idle", {busy, mem_we, rx_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 guarded configuration writes
        cfg(0, 8'h81); chk(start_pg == 8'h00, "R2 first page over limit", start_pg, 0);
        cfg(0, 8'h40); chk(start_pg == 8'h40, "R2 first page", start_pg, 8'h40);
        cfg(1, 8'h81); chk(stop_pg == 8'h00, "R2 end page over limit", stop_pg, 0);
        cfg(1, 8'h80); chk(stop_pg == 8'h80, "R2 end page at limit", stop_pg, 8'h80);
        cfg(2, 8'h80); chk(bnd_pg == 8'h00, "R2 boundary at limit", bnd_pg, 0);
        cfg(2, 8'h40); chk(bnd_pg == 8'h40, "R2 boundary", bnd_pg, 8'h40);
        cfg(3, 8'h80); chk(cur_pg == 8'h00, "R2 current at limit", cur_pg, 0);
        cfg(3, 8'h40); chk(cur_pg == 8'h40, "R2 current", cur_pg, 8'h40);
        // R3 refusal causes
        halt = 1'b1;
        send_frame(70, 1'b0, 3, 1'b1, 1'b0, "R3 halt");
        halt = 1'b0;
        send_frame(70, 1'b0, 5, 1'b0, 1'b0, "R3 not accepted");
        cfg(1, 8'h40);
        send_frame(70, 1'b0, 9, 1'b1, 1'b0, "R3 empty ring");
        cfg(1, 8'h80);
        // R4 R5 R6 R7 length sweep with host keeping pace
        for (int k = 0; k < 12; k++) begin
            cfg(2, int'(cur_pg));
            send_frame(lens[k], k[0], 11 + k * 13, 1'b1, 1'b1, "R5 sweep");
        end
        // R6 data folds past end page
        cfg(3, 8'h7F); cfg(2, 8'h7F);
        send_frame(600, 1'b1, 77, 1'b1, 1'b1, "R6 data wrap");
        chk(cur_pg == 8'h42, "R7 wrapped next page", cur_pg, 8'h42);
        // R7 only the pointer wraps
        cfg(3, 8'h7E); cfg(2, 8'h7E);
        send_frame(300, 1'b0, 91, 1'b1, 1'b1, "R7 pointer wrap");
        chk(cur_pg == 8'h40, "R7 pointer to first page", cur_pg, 8'h40);
        // R3 free space limit, boundary above current
        cfg(3, 8'h50); cfg(2, 8'h55);
        send_frame(100, 1'b0, 21, 1'b1, 1'b0, "R3 five pages free");
        cfg(2, 8'h56);
        send_frame(100, 1'b1, 23, 1'b1, 1'b1, "R3 six pages free");
        // R3 free space limit, boundary below current
        cfg(2, 8'h40); cfg(3, 8'h7B);
        send_frame(60, 1'b0, 31, 1'b1, 1'b0, "R3 behind five pages");
        cfg(3, 8'h7A);
        send_frame(60, 1'b0, 33, 1'b1, 1'b1, "R3 behind six pages");
        finished = 1'b1;
    end

    initial begin
        while (!finished && cyc < 150000) @(negedge clk);
        if (!finished) chk(1'b0, "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule